// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a fast input clock by a programmable ratio M = P·N + S. A dual-modulus prescaler counts input clocks and divides by either N+1 or N. A pulse counter counts prescaler output ticks up to P, and a swallow counter keeps the prescaler at N+1 for the first S ticks of each period. Each period therefore spends S·(N+1) input clocks in the high-modulus phase and (P−S)·N clocks in the low-modulus phase. At the end of the period the block emits a single-cycle output pulse. In the same cycle it reloads its programming words and starts the next period, with no dead cycles in between.

The block sits in the feedback path of a frequency synthesizer loop. The programming words P, S and N are sampled only at period boundaries, so a ratio change never produces a mixed period. The modulus-control signal is brought out so that the swallow phase can be observed. An error flag reports a swallow value larger than the pulse value.

Top module: `pswallow_divider`

## Requirements
- R1: While `rst` is high at a clock edge, `div_pulse` is driven 0. `cfg_err` and `mod_hi` take the values they would have at the start of a period built from the current inputs.
- R2: Consecutive `div_pulse` assertions are exactly P·N + S input clocks apart. The first pulse after reset release appears on the M-th rising edge after the last edge with `rst` high.
- R3: `div_pulse` is high for exactly one clock cycle per period.
- R4: Within every period, `mod_hi` (1 = divide by N+1, 0 = divide by N) is high for exactly S·(N+1) input clocks at the start of the period, and low for the rest.
- R5: With S = 0, `mod_hi` stays low for the whole period, and the period lasts P·N clocks.
- R6: With S = P, `mod_hi` stays high for the whole period, and the period lasts P·(N+1) clocks.
- R7: If S > P at a period boundary, `cfg_err` is high for that period and S is treated as P, so the period lasts P·N + P clocks. Otherwise `cfg_err` is low.
- R8: Changes to `p_word`, `s_word` or `n_word` take effect only at the next period boundary. The period in progress completes with the old ratio.
- R9: A `p_word` of 0 is treated as P = 1.
- R10: With the default widths and N = 16, every ratio M from 400 to 800 can be programmed and is produced exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| p_word | input | CNT_W | Pulse count P (prescaler ticks per period) |
| s_word | input | CNT_W | Swallow count S (ticks at modulus N+1) |
| n_word | input | N_W | Prescaler base modulus N, at least 2 |
| div_pulse | output | 1 | One-cycle pulse at the start of each output period |
| mod_hi | output | 1 | Modulus control: 1 selects N+1, 0 selects N |
| cfg_err | output | 1 | High for a period programmed with S > P |

## Verification
Each result is tied to a rising edge. The block reloads on the edge that ends a period, and `div_pulse` rises on that same edge. The gap and the count of high-modulus cycles for a period are therefore complete, and are judged, at the falling edge that follows the pulse edge. The bench captures the programming inputs at every rising edge. It drives new values 1 ns after an edge. The words sampled on the pulse edge become the expectation for the next period, and the words held earlier remain the expectation for the period still in progress. `cfg_err` is checked against the words captured on the pulse edge. The reset values are checked at falling edges while `rst` is high.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;

    // Default widths for the programming words.
    localparam int DEF_N_W   = 6;
    localparam int DEF_CNT_W = 8;

    // Prescaler modulus selection.
    typedef enum logic {
        MOD_BASE = 1'b0,   // divide by N
        MOD_PLUS = 1'b1    // divide by N+1
    } mod_e;

endpackage

// File: rtl/pswallow_prescaler.sv
module pswallow_prescaler #(
    parameter int N_W = pswallow_pkg::DEF_N_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N_W-1:0] n_base,
    input  pswallow_pkg::mod_e mod_sel,
    output logic           tick
);
    localparam int PC_W = N_W + 1;

    logic [PC_W-1:0] cnt;
    logic [PC_W-1:0] term;

    // Terminal count: N for modulus N+1, N-1 for modulus N.
    always_comb begin
        if (mod_sel == pswallow_pkg::MOD_PLUS)
            term = {1'b0, n_base};
        else
            term = {1'b0, n_base} - PC_W'(1);
    end

    assign tick = (cnt == term);

    always_ff @(posedge clk) begin
        if (rst || tick)
            cnt <= '0;
        else
            cnt <= cnt + PC_W'(1);
    end

    // The count never passes the larger modulus.
    assert_psc_limit_R2: assert property (@(posedge clk) disable iff (rst)
        cnt <= {1'b0, n_base});

endmodule

// File: rtl/pswallow_swallow_ctr.sv
module pswallow_swallow_ctr #(
    parameter int CNT_W = pswallow_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reload,
    input  logic [CNT_W-1:0] s_next,
    input  logic [CNT_W-1:0] s_cur,
    input  logic             tick,
    output pswallow_pkg::mod_e mod_sel
);
    logic [CNT_W-1:0] cnt;
    logic             last_swallow;

    assign last_swallow = ({1'b0, cnt} + (CNT_W+1)'(1)) == {1'b0, s_cur};

    always_ff @(posedge clk) begin
        if (rst || reload) begin
            cnt     <= '0;
            mod_sel <= (s_next != '0) ? pswallow_pkg::MOD_PLUS : pswallow_pkg::MOD_BASE;
        end else if (tick && mod_sel == pswallow_pkg::MOD_PLUS) begin
            cnt <= cnt + CNT_W'(1);
            if (last_swallow)
                mod_sel <= pswallow_pkg::MOD_BASE;
        end
    end

    // Swallowed ticks never exceed the programmed S.
    assert_swallow_bound_R4: assert property (@(posedge clk) disable iff (rst)
        cnt <= s_cur);

    // The modulus drops only on a prescaler tick.
    assert_mod_fall_tick_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(mod_sel) |-> $past(tick));

endmodule

// File: rtl/pswallow_pulse_ctr.sv
module pswallow_pulse_ctr #(
    parameter int CNT_W = pswallow_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] p_cur,
    input  logic             tick,
    output logic             period_end
);
    logic [CNT_W-1:0] cnt;

    assign period_end = tick && (({1'b0, cnt} + (CNT_W+1)'(1)) == {1'b0, p_cur});

    always_ff @(posedge clk) begin
        if (rst || period_end)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + CNT_W'(1);
    end

    // Ticks counted stay below P.
    assert_pulse_bound_R2: assert property (@(posedge clk) disable iff (rst)
        cnt < p_cur);

endmodule

// File: rtl/pswallow_divider.sv
module pswallow_divider #(
    parameter int N_W   = pswallow_pkg::DEF_N_W,
    parameter int CNT_W = pswallow_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] p_word,
    input  logic [CNT_W-1:0] s_word,
    input  logic [N_W-1:0]   n_word,
    output logic             div_pulse,
    output logic             mod_hi,
    output logic             cfg_err
);
    import pswallow_pkg::*;

    logic [CNT_W-1:0] p_eff, s_eff, p_q, s_q;
    logic [N_W-1:0]   n_q;
    logic             err_in;
    logic             tick, period_end;
    mod_e             mod_sel;

    // Clamp the programming words for the next period.
    always_comb begin
        p_eff  = (p_word == '0) ? CNT_W'(1) : p_word;
        err_in = (s_word > p_eff);
        s_eff  = err_in ? p_eff : s_word;
    end

    // The ratio is latched only at reset or at a period boundary.
    always_ff @(posedge clk) begin
        if (rst || period_end) begin
            p_q     <= p_eff;
            s_q     <= s_eff;
            n_q     <= n_word;
            cfg_err <= err_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            div_pulse <= 1'b0;
        else
            div_pulse <= period_end;
    end

    pswallow_prescaler #(.N_W(N_W)) u_psc (
        .clk     (clk),
        .rst     (rst),
        .n_base  (n_q),
        .mod_sel (mod_sel),
        .tick    (tick)
    );

    pswallow_swallow_ctr #(.CNT_W(CNT_W)) u_swl (
        .clk     (clk),
        .rst     (rst),
        .reload  (period_end),
        .s_next  (s_eff),
        .s_cur   (s_q),
        .tick    (tick),
        .mod_sel (mod_sel)
    );

    pswallow_pulse_ctr #(.CNT_W(CNT_W)) u_pls (
        .clk        (clk),
        .rst        (rst),
        .p_cur      (p_q),
        .tick       (tick),
        .period_end (period_end)
    );

    assign mod_hi = (mod_sel == MOD_PLUS);

    assert_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> !div_pulse);

    assert_start_mod_R4: assert property (@(posedge clk) disable iff (rst)
        div_pulse |-> (mod_hi == (s_q != '0)));

    assert_clamp_R7: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> (s_q == p_q));

    assert_mod_rise_boundary_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(mod_hi) |-> div_pulse);

endmodule

// File: tb/pswallow_divider_bench.sv
`timescale 1ns/100ps
module pswallow_divider_bench;
    localparam int N_W   = 6;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [CNT_W-1:0] p_word = 8'd25;
    logic [CNT_W-1:0] s_word = 8'd0;
    logic [N_W-1:0]   n_word = 6'd16;
    logic div_pulse, mod_hi, cfg_err;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    pswallow_divider #(.N_W(N_W), .CNT_W(CNT_W)) u_pswallow_divider (
        .clk(clk), .rst(rst), .p_word(p_word), .s_word(s_word), .n_word(n_word),
        .div_pulse(div_pulse), .mod_hi(mod_hi), .cfg_err(cfg_err)
    );

    function automatic int eff_p(int p);
        return (p == 0) ? 1 : p;
    endfunction
    function automatic int eff_s(int p, int s);
        return (s > eff_p(p)) ? eff_p(p) : s;
    endfunction
    function automatic int exp_m(int p, int s, int n);
        return eff_p(p) * n + eff_s(p, s);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Capture of the inputs at each rising edge.
    int cap_p, cap_s, cap_n;
    int edge_n = 0;
    int since_pulse = 0;
    always @(posedge clk) begin
        cap_p <= int'(p_word);
        cap_s <= int'(s_word);
        cap_n <= int'(n_word);
        if (rst) edge_n <= 0; else edge_n <= edge_n + 1;
        if (rst || div_pulse) since_pulse <= 0; else since_pulse <= since_pulse + 1;
    end

    // Period monitor at falling edges.
    int  cur_p, cur_s, cur_n;
    int  last_e = 0;
    int  hi_cnt = 0;
    int  pulses = 0;
    int  rst_checks = 0;
    bit  in_rst = 1'b1;
    bit  prev_pulse = 1'b0;
    bit  chg_flag = 1'b0;
    bit  done = 1'b0;
    string tag;

    always @(negedge clk) begin
        if (rst) begin
            if (rst_checks < 2) begin
                rst_checks++;
                // R1: reset state
                check(div_pulse == 1'b0, "R1 div_pulse", int'(div_pulse), 0);
                check(mod_hi == (eff_s(int'(p_word), int'(s_word)) != 0), "R1 mod_hi",
                      int'(mod_hi), int'(eff_s(int'(p_word), int'(s_word)) != 0));
            end
            in_rst = 1'b1;
            hi_cnt = 0;
            prev_pulse = 1'b0;
        end else begin
            if (in_rst) begin
                cur_p = cap_p; cur_s = cap_s; cur_n = cap_n;
                last_e = 0;
                in_rst = 1'b0;
            end
            if (div_pulse) begin
                if (chg_flag)                                   tag = "R8";
                else if (cur_p == 0)                            tag = "R9";
                else if (cur_s > cur_p)                         tag = "R7";
                else if (exp_m(cur_p, cur_s, cur_n) == 400 ||
                         exp_m(cur_p, cur_s, cur_n) == 800)     tag = "R10";
                else if (cur_s == 0)                            tag = "R5";
                else if (cur_s == cur_p)                        tag = "R6";
                else                                            tag = "R2";
                chg_flag = 1'b0;
                check(edge_n - last_e == exp_m(cur_p, cur_s, cur_n),
                      {tag, " period gap"}, edge_n - last_e, exp_m(cur_p, cur_s, cur_n));
                check(hi_cnt == eff_s(cur_p, cur_s) * (cur_n + 1),
                      "R4 high-modulus cycles", hi_cnt, eff_s(cur_p, cur_s) * (cur_n + 1));
                check(prev_pulse == 1'b0, "R3 single-cycle pulse", int'(prev_pulse), 0);
                check(cfg_err == (cap_s > eff_p(cap_p)), "R7 cfg_err",
                      int'(cfg_err), int'(cap_s > eff_p(cap_p)));
                cur_p = cap_p; cur_s = cap_s; cur_n = cap_n;
                last_e = edge_n;
                hi_cnt = 0;
                pulses++;
            end
            hi_cnt += int'(mod_hi);
            prev_pulse = div_pulse;
        end
    end

    // Watchdog.
    always @(negedge clk) begin
        if (!done && since_pulse > 4000) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog R2 actual=%0d expected=%0d", since_pulse, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic apply(input int p, input int s, input int n, input int delay);
        int base;
        repeat (delay) @(posedge clk);
        #1;
        p_word = CNT_W'(p);
        s_word = CNT_W'(s);
        n_word = N_W'(n);
        chg_flag = 1'b1;
        base = pulses;
        wait (pulses >= base + 3);
    endtask

    initial begin
        int p, s;
        void'($urandom(32'h5A17));
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        wait (pulses >= 2);
        apply(50, 0, 16, 37);    // R10 upper end, 800
        apply(30, 30, 16, 101);  // R6
        apply(26, 40, 16, 7);    // R7, 442
        apply(0, 3, 16, 3);      // R9, 17
        apply(3, 2, 5, 2);       // small N, 17
        apply(3, 0, 5, 4);       // R5 small
        apply(25, 0, 16, 11);    // R10 lower end, 400
        for (int i = 0; i < 12; i++) begin
            p = 25 + int'($urandom % 23);
            s = int'($urandom % (p + 1));
            apply(p, s, 16, 1 + int'($urandom % 300));
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule